// File: doc/BRIEF.md
# Address Match Break Controller

This block is a breakpoint unit with two channels. It watches the bus of a processor for accesses to a programmed address. Each channel holds a break address and a control byte. The control byte chooses which bus master to watch (the processor or a transfer controller that moves data on its own), how many low address bits to leave out of the comparison, and which access types trigger. It also holds an enable bit and a sticky match flag.

A matching access first becomes pending. For a channel that watches the processor, the flag sets when the accessing instruction retires, which `insn_done` signals. For a channel that watches the transfer controller, the flag sets on the first cycle in which the processor owns the bus again. Both channels share one registered break request line. Software finds the channel that raised it by reading the two flags. A flag clears only when software writes 0 to it after having read it as 1.

Software reaches the channels through a small register port. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `abrk_ctrl`

## Requirements
- R1: Register map by `reg_addr`: 2k is the break address of channel k, and 2k+1 is the control byte of channel k. The control byte reads as bit 0 enable, bits 2:1 condition, bits 5:3 mask code, bit 6 master select and bit 7 match flag. Written fields read back unchanged in the same cycle as the read strobe.
- R2: With mask code 000, a channel matches only when all ADDR_W address bits are equal to its break address.
- R3: Mask codes 001 to 111 leave the low 1, 2, 4, 8, 12, 16 and 24 address bits out of the comparison, in that order.
- R4: Condition 01 matches reads (`bus_write`=0), 10 matches writes, and 11 matches both. Condition 00 never matches.
- R5: Master select 0 watches only accesses with `bus_master`=0 (processor). Master select 1 watches only accesses with `bus_master`=1 (transfer controller).
- R6: A processor-channel match stays pending until `insn_done` is high. The flag reads 1 after the clock edge that samples `insn_done`, whether it comes in the access cycle or later.
- R7: A transfer-controller-channel match stays pending while `bus_master`=1. The flag reads 1 after the first edge that samples `bus_master`=0.
- R8: The hardware never clears a flag. A write of 0 to bit 7 clears the flag only if the control byte was read while the flag was 1. Without that read the flag stays set. A new match in the same cycle keeps the flag set.
- R9: `irq_o` goes high one edge after some channel has both its flag and its enable set while `bus_master`=0. It is low when no channel has flag and enable set, and low while the transfer controller owns the bus.
- R10: After reset all registers read 0, and `irq_o` and all pending state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_addr | input | ADDR_W | Access address |
| bus_write | input | 1 | 1 = write, 0 = read (stack and branch-target reads count as reads) |
| bus_master | input | 1 | Current bus owner: 0 = processor, 1 = transfer controller |
| insn_done | input | 1 | The processor instruction that made the access retires |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| irq_o | output | 1 | Shared break request |

## Verification
A register write or a completing access is seen in a flag on a read issued at the next falling edge, one edge later. The request output lags by one further edge. A transfer-controller match appears only after the edge that samples the return of bus ownership. The bench drives inputs at falling edges and samples `reg_rdata` 1 ns after it raises the read strobe. It places each check at the falling edge that follows the edge where that result is due. Random trials run a reference match function over address, mask, condition and master, and compare its result with both flags after the release cycle.

// File: rtl/abrk_pkg.sv
package abrk_pkg;

    typedef struct packed {
        logic       flag;
        logic       dma_sel;
        logic [2:0] mask;
        logic [1:0] cond;
        logic       en;
    } ctrl_t;

    localparam logic [1:0] COND_NONE  = 2'b00;
    localparam logic [1:0] COND_READ  = 2'b01;
    localparam logic [1:0] COND_WRITE = 2'b10;

    function automatic int ign_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 8;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/abrk_chan.sv
module abrk_chan
    import abrk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_ctrl,
    input  logic              rd_ctrl,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              bus_master,
    input  logic              insn_done,
    output logic [ADDR_W-1:0] addr_o,
    output ctrl_t             ctrl_o,
    output logic              req_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ctrl_t             ctrl;
        logic              pend;
        logic              armed;
    } chan_st_t;

    chan_st_t s_d, s_q;

    logic [ADDR_W-1:0] care;
    logic              type_ok;
    logic              hit_now;
    logic              live;
    logic              release_ok;
    logic              clr;

    always_comb begin
        int n;
        n = ign_bits(s_q.ctrl.mask);
        for (int i = 0; i < ADDR_W; i++) begin
            care[i] = (i >= n);
        end

        case (s_q.ctrl.cond)
            COND_NONE:  type_ok = 1'b0;
            COND_READ:  type_ok = !bus_write;
            COND_WRITE: type_ok = bus_write;
            default:    type_ok = 1'b1;
        endcase

        hit_now = bus_valid && (bus_master == s_q.ctrl.dma_sel) && type_ok
                  && (((bus_addr ^ s_q.addr) & care) == '0);
        live       = s_q.pend || hit_now;
        release_ok = s_q.ctrl.dma_sel ? !bus_master : insn_done;
        clr        = wr_ctrl && !wdata[7] && s_q.armed && s_q.ctrl.flag;

        s_d = s_q;
        if (wr_addr) begin
            s_d.addr = wdata;
        end
        if (wr_ctrl) begin
            s_d.ctrl.en      = wdata[0];
            s_d.ctrl.cond    = wdata[2:1];
            s_d.ctrl.mask    = wdata[5:3];
            s_d.ctrl.dma_sel = wdata[6];
        end
        if (rd_ctrl && s_q.ctrl.flag) begin
            s_d.armed = 1'b1;
        end
        if (clr) begin
            s_d.ctrl.flag = 1'b0;
            s_d.armed     = 1'b0;
        end
        if (live && release_ok) begin
            s_d.ctrl.flag = 1'b1;
            s_d.pend      = 1'b0;
        end else if (hit_now) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o = s_q.addr;
    assign ctrl_o = s_q.ctrl;
    assign req_o  = s_q.ctrl.flag && s_q.ctrl.en;

endmodule

// File: rtl/abrk_irq.sv
module abrk_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           bus_master,
    output logic           irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = (|req) && !bus_master;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/abrk_ctrl.sv
module abrk_ctrl
    import abrk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NCH    = 2,
    parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int RA_W   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              bus_master,
    input  logic              insn_done,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq_o
);

    logic [ADDR_W-1:0] ch_addr [NCH];
    ctrl_t             ch_ctrl [NCH];
    logic [NCH-1:0]    ch_req;
    logic [NCH-1:0]    flag_vec;
    logic [NCH-1:0]    en_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = (reg_addr[RA_W-1:1] == CH_W'(g));

        abrk_chan #(.ADDR_W(ADDR_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr    (reg_wr && sel && !reg_addr[0]),
            .wr_ctrl    (reg_wr && sel && reg_addr[0]),
            .rd_ctrl    (reg_rd && sel && reg_addr[0]),
            .wdata      (reg_wdata),
            .bus_valid  (bus_valid),
            .bus_addr   (bus_addr),
            .bus_write  (bus_write),
            .bus_master (bus_master),
            .insn_done  (insn_done),
            .addr_o     (ch_addr[g]),
            .ctrl_o     (ch_ctrl[g]),
            .req_o      (ch_req[g])
        );

        assign flag_vec[g] = ch_ctrl[g].flag;
        assign en_vec[g]   = ch_ctrl[g].en;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr[RA_W-1:1] == CH_W'(i)) begin
                reg_rdata = reg_addr[0] ? {{(ADDR_W-8){1'b0}}, ch_ctrl[i]}
                                        : ch_addr[i];
            end
        end
    end

    abrk_irq #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (ch_req),
        .bus_master (bus_master),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/abrk_chk.sv
module abrk_chk #(
    parameter int NCH  = 2,
    parameter int CH_W = 1,
    parameter int RA_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_master,
    input logic            insn_done,
    input logic            reg_wr,
    input logic [RA_W-1:0] reg_addr,
    input logic            wdata7,
    input logic [NCH-1:0]  flag_vec,
    input logic [NCH-1:0]  en_vec,
    input logic            irq_o
);

    // R9: a request needs a flagged, enabled channel one edge earlier
    a_r9_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(flag_vec & en_vec)));

    // R9: no request follows a cycle owned by the transfer controller
    a_r9_irq_cpu_owner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(!bus_master));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R8: a flag falls only after a zero write to its control byte
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_vec[g]) |->
                $past(reg_wr && (reg_addr == {CH_W'(g), 1'b1}) && !wdata7));

        // R6, R7: a flag rises only on a retire or processor-owned cycle
        a_r6_flag_on_release: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[g]) |-> $past(insn_done || !bus_master));
    end

endmodule

bind abrk_ctrl abrk_chk #(.NCH(NCH), .CH_W(CH_W), .RA_W(RA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_master (bus_master),
    .insn_done  (insn_done),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wdata7     (reg_wdata[7]),
    .flag_vec   (flag_vec),
    .en_vec     (en_vec),
    .irq_o      (irq_o)
);

// File: tb/abrk_ctrl_bench.sv
module abrk_ctrl_bench;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_write = 1'b0;
    logic          bus_master = 1'b0;
    logic          insn_done = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    abrk_ctrl u_abrk_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_master(bus_master), .insn_done(insn_done),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [AW-1:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        #1 check(req, reg_rdata, exp);
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic acc(input logic [AW-1:0] a, input bit w, input bit m, input bit d);
        bus_valid = 1'b1; bus_addr = a; bus_write = w; bus_master = m; insn_done = d;
        cyc();
        bus_valid = 1'b0; insn_done = 1'b0;
    endtask

    function automatic bit exp_hit(input logic [AW-1:0] base, input logic [7:0] c,
                                   input logic [AW-1:0] a, input bit w, input bit m);
        int  n;
        bit  tok, aok;
        case (c[5:3])
            3'd0: n = 0;  3'd1: n = 1;  3'd2: n = 2;  3'd3: n = 4;
            3'd4: n = 8;  3'd5: n = 12; 3'd6: n = 16; default: n = 24;
        endcase
        case (c[2:1])
            2'b00: tok = 0;
            2'b01: tok = !w;
            2'b10: tok = w;
            default: tok = 1;
        endcase
        aok = (n >= AW) ? 1'b1 : ((base >> n) == (a >> n));
        return tok && aok && (m == c[6]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base [2];
        logic [7:0]    cv   [2];
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 irq", AW'(irq_o), 0);
        for (int i = 0; i < 4; i++) rd_chk("R10 reg", 2'(i), 0);

        // R1 programming and readback
        wr(0, 24'h123456); wr(1, 24'h07);
        rd_chk("R1 addr0", 0, 24'h123456);
        rd_chk("R1 ctrl0", 1, 24'h07);

        // R6 pending until retire, R2 exact match
        acc(24'h123456, 0, 0, 0);
        check("R6 irq before retire", AW'(irq_o), 0);
        insn_done = 1'b1; cyc(); insn_done = 1'b0;
        check("R9 irq one edge later", AW'(irq_o), 0);
        cyc();
        check("R9 irq raised", AW'(irq_o), 1);
        wr(1, 24'h07);
        rd_chk("R8 unread zero write ignored", 1, 24'h87);
        wr(1, 24'h07);
        rd_chk("R8 cleared after read", 1, 24'h07);
        check("R9 irq dropped", AW'(irq_o), 0);

        // R3 mask code 4 ignores 8 bits
        wr(0, 24'h123400); wr(1, 24'h27);
        acc(24'h1234FF, 1, 0, 1);
        rd_chk("R3 masked hit", 1, 24'hA7);
        wr(1, 24'h27);
        acc(24'h123500, 0, 0, 1);
        rd_chk("R3 outside mask", 1, 24'h27);

        // R4 conditions
        wr(0, 24'h000100); wr(1, 24'h03);
        acc(24'h000100, 1, 0, 1);
        rd_chk("R4 read-only ignores write", 1, 24'h03);
        wr(1, 24'h01);
        acc(24'h000100, 0, 0, 1);
        acc(24'h000100, 1, 0, 1);
        rd_chk("R4 cond 00 never", 1, 24'h01);

        // R5 processor channel ignores transfer-controller access
        wr(1, 24'h07);
        acc(24'h000100, 0, 1, 1);
        rd_chk("R5 master mismatch", 1, 24'h07);
        bus_master = 1'b0;
        cyc();

        // R7 deferral while transfer controller owns the bus
        wr(2, 24'h00ABCD); wr(3, 24'h45);
        rd_chk("R1 addr1", 2, 24'h00ABCD);
        acc(24'h00ABCD, 1, 1, 1);
        rd_chk("R7 held during tenure", 3, 24'h45);
        cyc();
        rd_chk("R7 still held", 3, 24'h45);
        check("R9 no irq during tenure", AW'(irq_o), 0);
        bus_master = 1'b0;
        cyc();
        rd_chk("R7 set on return", 3, 24'hC5);
        check("R9 irq after return", AW'(irq_o), 1);
        bus_master = 1'b1; cyc();
        check("R9 irq gated by owner", AW'(irq_o), 0);
        bus_master = 1'b0; cyc();
        check("R9 irq back", AW'(irq_o), 1);

        // R9 enable off: flag sets, no request
        wr(3, 24'h44);
        rd_chk("R8 clear ch1", 3, 24'h44);
        acc(24'h00ABCD, 1, 1, 0);
        bus_master = 1'b0; cyc();
        rd_chk("R9 flag without enable", 3, 24'hC4);
        cyc(); cyc();
        check("R9 no irq without enable", AW'(irq_o), 0);
        wr(3, 24'h44);
        rd_chk("R8 clear ch1 again", 3, 24'h44);

        // Random trials R2 R3 R4 R5
        void'($urandom(32'hB2EA_0001));
        for (int t = 0; t < 400; t++) begin
            int k, wbits;
            logic [AW-1:0] a;
            bit w, m;
            for (int c = 0; c < 2; c++) begin
                base[c] = AW'($urandom);
                cv[c]   = 8'($urandom) & 8'h7F;
                wr(2'(2*c), base[c]);
                wr(2'(2*c+1), AW'(cv[c]));
            end
            k     = $urandom_range(1, 0);
            wbits = $urandom_range(AW, 0);
            a     = base[k] ^ (AW'($urandom) & ((AW'(1) << wbits) - AW'(1)));
            if (wbits == AW) a = AW'($urandom);
            w = 1'($urandom); m = 1'($urandom);
            acc(a, w, m, 1);
            bus_master = 1'b0; cyc();
            for (int c = 0; c < 2; c++) begin
                logic [7:0] e;
                e = cv[c] | (exp_hit(base[c], cv[c], a, w, m) ? 8'h80 : 8'h00);
                rd_chk("R3 random match", 2'(2*c+1), AW'(e));
                wr(2'(2*c+1), AW'(cv[c]));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule